// File: doc/BRIEF.md
# Inter-processor and timer interrupt unit

This unit keeps two pending bitmaps with one bit per processor. One bitmap holds inter-processor interrupts and the other holds interval-timer interrupts. Software changes them with register writes. A write to the control register carries three nibbles: one nibble requests inter-processor interrupts, one clears them, and one clears timer interrupts. Three further registers each take a plain processor bitmask, and each does one of those three jobs.

A timer tick input marks a timer interrupt pending on every present processor. A processor counts as present when its index is below the `present_cnt` input. Bits that target absent processors have no effect. For each processor the unit drives an inter-processor line, a timer line and an encoded level. The level gives inter-processor interrupts priority over timer interrupts. The control register read view returns both bitmaps.

Top module: `irqu_top`

## Requirements
- R1: Reset clears both bitmaps. After reset, every interrupt line, every level code and `rd_data` are zero.
- R2: A write with `wr_sel`=0 sets the inter-processor pending bit of processor i when `wr_data` bit 12+i is 1.
- R3: A write with `wr_sel`=0 clears the inter-processor pending bit of processor i when `wr_data` bit 8+i is 1.
- R4: A write with `wr_sel`=0 clears the timer pending bit of processor i when `wr_data` bit 4+i is 1.
- R5: If one write both clears and requests the inter-processor interrupt of the same processor, the clear is applied first. That interrupt is pending afterwards.
- R6: A request to a processor that is already pending, a clear of a processor that is not pending, or a write with all fields zero leaves both bitmaps unchanged.
- R7: A cycle with `tick`=1 sets the timer pending bit of every present processor. This holds even when the same cycle carries a timer clear.
- R8: Bit i of `wr_data` acts on processor i. With `wr_sel`=1 it requests an inter-processor interrupt, with `wr_sel`=2 it clears one, and with `wr_sel`=3 it clears a timer interrupt.
- R9: Only processors with an index below `present_cnt` are affected by requests, clears or ticks. Bits for other processors are ignored.
- R10: `rd_data` shows the inter-processor bitmap in bits 11:8 and the timer bitmap in bits 7:4. All other bits are zero.
- R11: For processor i, `irq_lvl[2i+1:2i]` is 2 if an inter-processor interrupt is pending. Otherwise it is 1 if a timer interrupt is pending, and 0 if nothing is pending.
- R12: The bitmaps change only on the clock edge that samples a write with `wr_en`=1 or a tick. The result is visible from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| present_cnt | input | CNT_W | Number of present processors |
| tick | input | 1 | Interval-timer tick, one cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 request, 2 clear, 3 timer clear |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Control register read view |
| ipi_irq | output | NCPU | Inter-processor interrupt per processor |
| tmr_irq | output | NCPU | Timer interrupt per processor |
| irq_lvl | output | 2*NCPU | Encoded highest pending level per processor |

## Verification
A wrong bit in either bitmap reaches `ipi_irq` or `tmr_irq`, `rd_data` and `irq_lvl` on the edge right after the write or tick that caused it. A single sample one cycle later therefore exposes it. A bad clear-versus-request order or a bad tick-versus-clear order leaves the wrong value on one line. That value persists until a later write changes it, so the following rows of the vector table also show the error. A fault in the present mask shows up as a line that rises on an absent processor.

// File: rtl/irqu_pkg.sv
package irqu_pkg;
    typedef enum logic [1:0] {
        LVL_NONE  = 2'd0,
        LVL_TIMER = 2'd1,
        LVL_IPI   = 2'd2
    } irq_lvl_e;

    typedef enum logic [1:0] {
        SEL_CTL     = 2'd0,
        SEL_IPI_REQ = 2'd1,
        SEL_IPI_CLR = 2'd2,
        SEL_TMR_CLR = 2'd3
    } reg_sel_e;

    localparam int IPI_REQ_LSB = 12;
    localparam int IPI_CLR_LSB = 8;
    localparam int TMR_CLR_LSB = 4;
endpackage

// File: rtl/irqu_present.sv
module irqu_present #(
    parameter int NCPU  = 4,
    parameter int CNT_W = $clog2(NCPU + 1)
) (
    input  logic [CNT_W-1:0] present_cnt,
    output logic [NCPU-1:0]  pmask
);
    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        assign pmask[i] = (present_cnt > CNT_W'(i));
    end
endmodule

// File: rtl/irqu_wdec.sv
module irqu_wdec
    import irqu_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int DATA_W = 16
) (
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NCPU-1:0]   pmask,
    output logic [NCPU-1:0]   ipi_set,
    output logic [NCPU-1:0]   ipi_clr,
    output logic [NCPU-1:0]   tmr_clr
);
    logic unused_data;
    assign unused_data = ^wr_data;

    always_comb begin
        ipi_set = '0;
        ipi_clr = '0;
        tmr_clr = '0;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_CTL: begin
                    ipi_set = wr_data[IPI_REQ_LSB +: NCPU];
                    ipi_clr = wr_data[IPI_CLR_LSB +: NCPU];
                    tmr_clr = wr_data[TMR_CLR_LSB +: NCPU];
                end
                SEL_IPI_REQ: ipi_set = wr_data[NCPU-1:0];
                SEL_IPI_CLR: ipi_clr = wr_data[NCPU-1:0];
                SEL_TMR_CLR: tmr_clr = wr_data[NCPU-1:0];
                default: ;
            endcase
        end
        ipi_set &= pmask;
        ipi_clr &= pmask;
        tmr_clr &= pmask;
    end
endmodule

// File: rtl/irqu_state.sv
module irqu_state #(
    parameter int NCPU = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCPU-1:0] ipi_set,
    input  logic [NCPU-1:0] ipi_clr,
    input  logic [NCPU-1:0] tmr_set,
    input  logic [NCPU-1:0] tmr_clr,
    output logic [NCPU-1:0] ipi_q,
    output logic [NCPU-1:0] tmr_q
);
    typedef struct packed {
        logic [NCPU-1:0] ipi;
        logic [NCPU-1:0] tmr;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ipi = (st_q.ipi & ~ipi_clr) | ipi_set;
        st_d.tmr = (st_q.tmr & ~tmr_clr) | tmr_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ipi_q = st_q.ipi;
    assign tmr_q = st_q.tmr;

    assert_req_pends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ipi_set != '0) |=> ((ipi_q & $past(ipi_set)) == $past(ipi_set)));

    assert_ipi_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ipi_clr & ~ipi_set) != '0) |=> ((ipi_q & $past(ipi_clr & ~ipi_set)) == '0));

    assert_tick_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_set != '0) |=> ((tmr_q & $past(tmr_set)) == $past(tmr_set)));

    assert_ipi_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ipi_set == '0 && ipi_clr == '0) |=> $stable(ipi_q));

    assert_tmr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_set == '0 && tmr_clr == '0) |=> $stable(tmr_q));
endmodule

// File: rtl/irqu_top.sv
module irqu_top
    import irqu_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int DATA_W = 16,
    parameter int CNT_W  = $clog2(NCPU + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    present_cnt,
    input  logic                tick,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NCPU-1:0]     ipi_irq,
    output logic [NCPU-1:0]     tmr_irq,
    output logic [2*NCPU-1:0]   irq_lvl
);
    logic [NCPU-1:0] pmask, ipi_set, ipi_clr, tmr_clr, tmr_set;

    irqu_present #(.NCPU(NCPU), .CNT_W(CNT_W)) i_present (
        .present_cnt (present_cnt),
        .pmask       (pmask)
    );

    irqu_wdec #(.NCPU(NCPU), .DATA_W(DATA_W)) i_wdec (
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pmask   (pmask),
        .ipi_set (ipi_set),
        .ipi_clr (ipi_clr),
        .tmr_clr (tmr_clr)
    );

    assign tmr_set = tick ? pmask : '0;

    irqu_state #(.NCPU(NCPU)) i_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .ipi_set (ipi_set),
        .ipi_clr (ipi_clr),
        .tmr_set (tmr_set),
        .tmr_clr (tmr_clr),
        .ipi_q   (ipi_irq),
        .tmr_q   (tmr_irq)
    );

    always_comb begin
        rd_data = '0;
        rd_data[IPI_CLR_LSB +: NCPU] = ipi_irq;
        rd_data[TMR_CLR_LSB +: NCPU] = tmr_irq;
    end

    for (genvar i = 0; i < NCPU; i++) begin : g_lvl
        irq_lvl_e lvl;
        always_comb begin
            if (ipi_irq[i])      lvl = LVL_IPI;
            else if (tmr_irq[i]) lvl = LVL_TIMER;
            else                 lvl = LVL_NONE;
        end
        assign irq_lvl[2*i +: 2] = lvl;

        assert_ipi_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ipi_irq[i] |-> (irq_lvl[2*i +: 2] == LVL_IPI));
    end

    assert_absent_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (((ipi_irq & ~$past(ipi_irq)) | (tmr_irq & ~$past(tmr_irq))) & ~$past(pmask)) == '0);
endmodule

// File: tb/test_irqu_top.sv
`timescale 1ns/1ps
module test_irqu_top;
    localparam int NCPU = 4;
    localparam int DW   = 16;
    localparam int CW   = 3;
    localparam int NV   = 18;

    logic clk = 1'b0;
    logic rst_n;
    logic [CW-1:0] present_cnt;
    logic tick, wr_en;
    logic [1:0] wr_sel;
    logic [DW-1:0] wr_data, rd_data;
    logic [NCPU-1:0] ipi_irq, tmr_irq;
    logic [2*NCPU-1:0] irq_lvl;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irqu_top #(.NCPU(NCPU), .DATA_W(DW), .CNT_W(CW)) i_irqu_top (
        .clk(clk), .rst_n(rst_n), .present_cnt(present_cnt), .tick(tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_data(rd_data),
        .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .irq_lvl(irq_lvl)
    );

    // {we, sel, data, tick, present, expected ipi, expected tmr}
    localparam logic [30:0] VECS [NV] = '{
        {1'b1, 2'd0, 16'h5000, 1'b0, 3'd4, 4'h5, 4'h0},  // R2
        {1'b1, 2'd0, 16'hA000, 1'b0, 3'd4, 4'hF, 4'h0},  // R2
        {1'b1, 2'd0, 16'h0300, 1'b0, 3'd4, 4'hC, 4'h0},  // R3
        {1'b0, 2'd0, 16'h0000, 1'b1, 3'd4, 4'hC, 4'hF},  // R7
        {1'b1, 2'd0, 16'h0060, 1'b0, 3'd4, 4'hC, 4'h9},  // R4
        {1'b1, 2'd0, 16'h4000, 1'b0, 3'd4, 4'hC, 4'h9},  // R6
        {1'b1, 2'd0, 16'h0030, 1'b0, 3'd4, 4'hC, 4'h8},  // R6
        {1'b1, 2'd0, 16'h1100, 1'b0, 3'd4, 4'hD, 4'h8},  // R5
        {1'b1, 2'd0, 16'h4400, 1'b0, 3'd4, 4'hD, 4'h8},  // R5
        {1'b1, 2'd3, 16'h000F, 1'b0, 3'd4, 4'hD, 4'h0},  // R8
        {1'b1, 2'd1, 16'h0002, 1'b0, 3'd4, 4'hF, 4'h0},  // R8
        {1'b1, 2'd2, 16'h0009, 1'b0, 3'd4, 4'h6, 4'h0},  // R8
        {1'b0, 2'd0, 16'h0000, 1'b1, 3'd2, 4'h6, 4'h3},  // R9
        {1'b1, 2'd1, 16'h000F, 1'b0, 3'd2, 4'h7, 4'h3},  // R9
        {1'b1, 2'd0, 16'hC000, 1'b0, 3'd2, 4'h7, 4'h3},  // R9
        {1'b1, 2'd2, 16'h0004, 1'b0, 3'd2, 4'h7, 4'h3},  // R9
        {1'b1, 2'd0, 16'h00F0, 1'b1, 3'd4, 4'h7, 4'hF},  // R7
        {1'b1, 2'd0, 16'h0000, 1'b0, 3'd4, 4'h7, 4'hF}   // R6
    };

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_lvl(logic [3:0] ipi, logic [3:0] tmr);
        logic [7:0] l = '0;
        for (int i = 0; i < NCPU; i++)
            l[2*i +: 2] = ipi[i] ? 2'd2 : (tmr[i] ? 2'd1 : 2'd0);
        return l;
    endfunction

    task automatic check_state(string req, logic [3:0] ipi, logic [3:0] tmr);
        check(req, {12'b0, ipi_irq}, {12'b0, ipi});
        check(req, {12'b0, tmr_irq}, {12'b0, tmr});
        check({req, "/R10"}, rd_data, {4'b0, ipi, tmr, 4'b0});
        check({req, "/R11"}, {8'b0, irq_lvl}, {8'b0, exp_lvl(ipi, tmr)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; present_cnt = 3'd4; tick = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
        repeat (3) @(negedge clk);
        check_state("R1 reset", 4'h0, 4'h0);
        rst_n = 1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            {wr_en, wr_sel, wr_data, tick, present_cnt} = VECS[v][30:8];
            @(negedge clk);
            wr_en = 0; tick = 0;
            check_state($sformatf("vector %0d", v), VECS[v][7:4], VECS[v][3:0]);
        end

        // R12: data on the bus without a strobe changes nothing
        wr_sel = 2'd0; wr_data = 16'hFFFF; wr_en = 0;
        repeat (2) @(negedge clk);
        check_state("R12 no strobe", 4'h7, 4'hF);

        // R12: new value visible right after the sampling edge
        wr_sel = 2'd2; wr_data = 16'h0001; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
        check_state("R12 one edge", 4'h6, 4'hF);

        // R1: reset in mid-run clears everything
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check_state("R1 mid-run reset", 4'h0, 4'h0);

        // R9: zero present processors ignore the tick
        present_cnt = 3'd0; tick = 1;
        @(negedge clk);
        tick = 0;
        check_state("R9 none present", 4'h0, 4'h0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule